// File: doc/BRIEF.md
# One-Time-Programmable Word Burn Sequencer

This block burns one data word into a one-time-programmable fuse array each time a host asks for it. The host first writes the control register with the target word address and a 16-bit arming key in the same write. It then writes the data register, and that write starts the operation. The sequencer copies the address and the data, reads the word as it stands now in the fuse array, and removes every bit that is already blown. It then steps through the remaining positions from bit 0 upward. Each position holding a one gets its own program strobe, with a settle interval on each side of it. The data register shifts right with zero fill as positions are passed.

Pulse lengths come from a timing register in bus-clock cycles. When the operation ends, a quiet window whose length is derived from the clock frequency parameter blocks the next operation. A word whose lock input is set is never touched: the request raises an error flag instead. The block is meant to sit behind a simple register bus, with its serial port wired to the fuse macro.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset the control, timing and data registers read 0, and the program strobe and fuse read enable are low.
- R2: Register select encoding: 0 control, 1 error clear, 2 timing, 3 data. A data write starts an operation only if control bits 31:16 hold 0x3E77. Without that key the write is ignored: busy (control bit 8) stays 0 and the data register is unchanged.
- R3: An accepted data write sets busy one cycle later and clears control bits 31:16 to 0. A further data write made without writing the key again starts nothing.
- R4: The fuse read enable is high for max(STROBE_READ,1) cycles at the start of the operation. Only bit positions that are 1 in the data and 0 in the current fuse word receive a strobe, so no fuse bit is struck twice.
- R5: Strobes go out in ascending bit order, each high for max(STROBE_PROG,1) cycles. The bit index output names the position being burned.
- R6: The word address is captured when the operation starts. Control writes during busy do not change the word that is burned.
- R7: The data register shifts right with zero fill, one position per bit scanned. At the strobe for bit k it reads (data & ~fuse) >> k. It reads 0 at the end. Data writes during busy are ignored.
- R8: A keyed request to a word whose lock input is set causes no fuse access and does not set busy. It sets error (control bit 9) and consumes the key. While error is set, data writes are ignored. Writing 1 to bit 9 of the error-clear register clears error.
- R9: After busy falls, control bit 12 is high for 2 us worth of cycles (200 at 100 MHz). During that window data writes are ignored and the key is kept.
- R10: The timing register holds STROBE_PROG in bits 11:0, RELAX in bits 15:12 and STROBE_READ in bits 21:16. Bits 31:22 read 0.
- R11: Adjacent burned bits are separated by 2*max(RELAX,1)+1 strobe-low cycles. A RELAX of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 ctrl, 1 error clear, 2 timing, 3 data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| lock_vec | input | 256 | One lock flag per fuse word |
| fuse_addr | output | 8 | Captured word address to the fuse array |
| fuse_rd_en | output | 1 | Fuse word read enable |
| fuse_rd_data | input | 32 | Current fuse word contents |
| fuse_bit_idx | output | 5 | Bit position being programmed |
| fuse_bit_val | output | 1 | Bit data: high while a position is being burned |
| fuse_strobe | output | 1 | Program strobe |

## Verification
A wrong sequencer state shows up directly at the serial port. A bad mask strikes an already-blown fuse bit, which is seen the moment that strobe rises. A wrong counter reload stretches or shortens a strobe or a settle gap, which is visible within one bit period. A stale address sends the strobes to another word. A key or error flag left in the wrong state is seen within two cycles of the next data write: either busy rises when it should not, or it fails to rise. A miscounted quiet window shows up as a wrong number of cycles with bit 12 set after busy falls.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

   localparam int BUSY_BIT   = 8;
   localparam int ERR_BIT    = 9;
   localparam int SETTLE_BIT = 12;
   localparam int KEY_LSB    = 16;
   localparam int TIME_W     = 22;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_CLR  = 2'd1,
      SEL_TIME = 2'd2,
      SEL_DATA = 2'd3
   } reg_sel_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_SCAN,
      ST_SETUP,
      ST_STROBE,
      ST_HOLD
   } eng_state_e;

   // packed to match the register field layout: read 21:16, relax 15:12, prog 11:0
   typedef struct packed {
      logic [5:0]  rd;
      logic [3:0]  relax;
      logic [11:0] prog;
   } timing_t;

endpackage

// File: rtl/otp_seq_regs.sv
module otp_seq_regs
   import otp_seq_pkg::*;
#(
   parameter int          DATA_W = 32,
   parameter int          ADDR_W = 8,
   parameter logic [15:0] KEY    = 16'h3E77
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_we,
   input  logic [1:0]              reg_sel,
   input  logic [31:0]             reg_wdata,
   output logic [31:0]             reg_rdata,
   input  logic [(1<<ADDR_W)-1:0]  lock_vec,
   input  logic                    eng_busy,
   input  logic                    settle_busy,
   input  logic [DATA_W-1:0]       eng_data,
   output logic                    start,
   output logic [ADDR_W-1:0]       start_addr,
   output logic [DATA_W-1:0]       start_data,
   output timing_t                 timing
);

   logic [ADDR_W-1:0] addr_q;
   logic [15:0]       key_q;
   logic              err_q;
   timing_t           tim_q;

   logic wr_ctrl, wr_clr, wr_time, wr_data;
   logic key_ok, ready, try_go, reject;

   assign wr_ctrl = reg_we && (reg_sel == SEL_CTRL);
   assign wr_clr  = reg_we && (reg_sel == SEL_CLR);
   assign wr_time = reg_we && (reg_sel == SEL_TIME);
   assign wr_data = reg_we && (reg_sel == SEL_DATA);

   assign key_ok = (key_q == KEY);
   assign ready  = !eng_busy && !settle_busy && !err_q;
   assign try_go = wr_data && key_ok && ready;
   assign reject = try_go && lock_vec[addr_q];
   assign start  = try_go && !lock_vec[addr_q];

   assign start_addr = addr_q;
   assign start_data = reg_wdata[DATA_W-1:0];
   assign timing     = tim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         key_q  <= '0;
         err_q  <= 1'b0;
         tim_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            addr_q <= reg_wdata[ADDR_W-1:0];
            key_q  <= reg_wdata[31:KEY_LSB];
         end else if (try_go) begin
            key_q  <= '0;
         end
         if (reject)
            err_q <= 1'b1;
         else if (wr_clr && reg_wdata[ERR_BIT])
            err_q <= 1'b0;
         if (wr_time)
            tim_q <= timing_t'(reg_wdata[TIME_W-1:0]);
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel_e'(reg_sel))
         SEL_CTRL: begin
            reg_rdata[ADDR_W-1:0]   = addr_q;
            reg_rdata[BUSY_BIT]     = eng_busy;
            reg_rdata[ERR_BIT]      = err_q;
            reg_rdata[SETTLE_BIT]   = settle_busy;
            reg_rdata[31:KEY_LSB]   = key_q;
         end
         SEL_TIME: reg_rdata[TIME_W-1:0] = tim_q;
         SEL_DATA: reg_rdata[DATA_W-1:0] = eng_data;
         default:  reg_rdata = '0;
      endcase
   end

   // R8
   lock_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reject |=> (err_q && !eng_busy));

endmodule

// File: rtl/otp_seq_engine.sv
module otp_seq_engine
   import otp_seq_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int FULL_SCAN = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [ADDR_W-1:0]         start_addr,
   input  logic [DATA_W-1:0]         start_data,
   input  timing_t                   timing,
   input  logic [DATA_W-1:0]         fuse_rd_data,
   output logic                      busy,
   output logic                      done,
   output logic [DATA_W-1:0]         data_out,
   output logic [ADDR_W-1:0]         fuse_addr,
   output logic                      fuse_rd_en,
   output logic [$clog2(DATA_W)-1:0] fuse_bit_idx,
   output logic                      fuse_bit_val,
   output logic                      fuse_strobe
);

   localparam int POS_W = $clog2(DATA_W);
   localparam int IDX_W = POS_W + 1;
   localparam int CNT_W = 12;

   eng_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] data_q;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] addr_q;

   logic [CNT_W-1:0] prog_len, relax_len, read_len;
   logic             all_done;
   logic             cnt_zero;

   assign prog_len  = (timing.prog  == '0) ? CNT_W'(1) : timing.prog;
   assign relax_len = (timing.relax == '0) ? CNT_W'(1) : CNT_W'(timing.relax);
   assign read_len  = (timing.rd    == '0) ? CNT_W'(1) : CNT_W'(timing.rd);
   assign cnt_zero  = (cnt == '0);

   generate
      if (FULL_SCAN != 0) begin : g_full
         assign all_done = (idx == IDX_W'(DATA_W));
      end else begin : g_early
         assign all_done = (data_q == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         data_q <= '0;
         idx    <= '0;
         addr_q <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               st     <= ST_READ;
               addr_q <= start_addr;
               data_q <= start_data;
               idx    <= '0;
               cnt    <= read_len - CNT_W'(1);
            end
            ST_READ: if (cnt_zero) begin
               data_q <= data_q & ~fuse_rd_data;
               st     <= ST_SCAN;
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
            ST_SCAN: if (all_done) begin
               st <= ST_IDLE;
            end else if (data_q[0]) begin
               st  <= ST_SETUP;
               cnt <= relax_len - CNT_W'(1);
            end else begin
               data_q <= data_q >> 1;
               idx    <= idx + IDX_W'(1);
            end
            ST_SETUP: if (cnt_zero) begin
               st  <= ST_STROBE;
               cnt <= prog_len - CNT_W'(1);
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
            ST_STROBE: if (cnt_zero) begin
               st  <= ST_HOLD;
               cnt <= relax_len - CNT_W'(1);
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
            ST_HOLD: if (cnt_zero) begin
               st     <= ST_SCAN;
               data_q <= data_q >> 1;
               idx    <= idx + IDX_W'(1);
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy         = (st != ST_IDLE);
   assign done         = (st == ST_SCAN) && all_done;
   assign data_out     = data_q;
   assign fuse_addr    = addr_q;
   assign fuse_rd_en   = (st == ST_READ);
   assign fuse_strobe  = (st == ST_STROBE);
   assign fuse_bit_val = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);
   assign fuse_bit_idx = idx[POS_W-1:0];

   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(addr_q));

   // R7
   ones_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($countones(data_q) <= $countones($past(data_q))));

   // R5
   strobe_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_strobe |-> data_q[0]);

   // R5
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (idx <= IDX_W'(DATA_W)));

endmodule

// File: rtl/otp_seq_settle.sv
module otp_seq_settle #(
   parameter int QUIET_CYC = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   output logic settle_busy
);

   localparam int CNT_W = $clog2(QUIET_CYC + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (done)
         cnt <= CNT_W'(QUIET_CYC);
      else if (cnt != '0)
         cnt <= cnt - CNT_W'(1);
   end

   assign settle_busy = (cnt != '0);

   // R9
   settle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> settle_busy);

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
   import otp_seq_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 8,
   parameter int          CLK_MHZ   = 100,
   parameter int          QUIET_NS  = 2000,
   parameter logic [15:0] KEY       = 16'h3E77,
   parameter int          FULL_SCAN = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_we,
   input  logic [1:0]                reg_sel,
   input  logic [31:0]               reg_wdata,
   output logic [31:0]               reg_rdata,
   input  logic [(1<<ADDR_W)-1:0]    lock_vec,
   output logic [ADDR_W-1:0]         fuse_addr,
   output logic                      fuse_rd_en,
   input  logic [DATA_W-1:0]         fuse_rd_data,
   output logic [$clog2(DATA_W)-1:0] fuse_bit_idx,
   output logic                      fuse_bit_val,
   output logic                      fuse_strobe
);

   localparam int QUIET_CYC = (CLK_MHZ * QUIET_NS + 999) / 1000;

   generate
      if (DATA_W < 2 || DATA_W > 32) begin : g_bad_data
         $error("DATA_W must lie in 2..32");
      end
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
         $error("ADDR_W must lie in 1..8");
      end
      if (QUIET_CYC < 1) begin : g_bad_quiet
         $error("quiet window must be at least one cycle");
      end
   endgenerate

   logic              start, eng_busy, eng_done, settle_busy;
   logic [ADDR_W-1:0] start_addr;
   logic [DATA_W-1:0] start_data, eng_data;
   timing_t           timing;

   otp_seq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY(KEY)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .lock_vec(lock_vec),
      .eng_busy(eng_busy), .settle_busy(settle_busy), .eng_data(eng_data),
      .start(start), .start_addr(start_addr), .start_data(start_data),
      .timing(timing)
   );

   otp_seq_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FULL_SCAN(FULL_SCAN)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .start(start), .start_addr(start_addr), .start_data(start_data),
      .timing(timing), .fuse_rd_data(fuse_rd_data),
      .busy(eng_busy), .done(eng_done), .data_out(eng_data),
      .fuse_addr(fuse_addr), .fuse_rd_en(fuse_rd_en),
      .fuse_bit_idx(fuse_bit_idx), .fuse_bit_val(fuse_bit_val),
      .fuse_strobe(fuse_strobe)
   );

   otp_seq_settle #(.QUIET_CYC(QUIET_CYC)) u_settle (
      .clk(clk), .rst_n(rst_n), .done(eng_done), .settle_busy(settle_busy)
   );

   // R3
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> eng_busy);

   // R9
   settle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      settle_busy |-> !eng_busy);

   // R4
   read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_busy) |-> fuse_rd_en);

endmodule

// File: tb/otp_prog_seq_tb.sv
module otp_prog_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [255:0] lock_vec = '0;
   logic [7:0]  fuse_addr;
   logic        fuse_rd_en;
   logic [31:0] fuse_rd_data;
   logic [4:0]  fuse_bit_idx;
   logic        fuse_bit_val;
   logic        fuse_strobe;

   logic [31:0] fmem [256];

   int checks = 0;
   int errors = 0;

   int pulses, dbl, order_bad, wmin, wmax, gmin, gmax, rd_cyc, cur_w, gap_cnt, last_idx;
   bit prev_s = 1'b0;

   localparam logic [1:0] S_CTRL = 2'd0, S_CLR = 2'd1, S_TIME = 2'd2, S_DATA = 2'd3;
   localparam logic [31:0] KEYW = 32'h3E77_0000;

   always #5 clk = ~clk;

   assign fuse_rd_data = fmem[fuse_addr];

   otp_prog_seq u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lock_vec(lock_vec),
      .fuse_addr(fuse_addr), .fuse_rd_en(fuse_rd_en), .fuse_rd_data(fuse_rd_data),
      .fuse_bit_idx(fuse_bit_idx), .fuse_bit_val(fuse_bit_val),
      .fuse_strobe(fuse_strobe)
   );

   // serial port monitor and fuse model
   always @(negedge clk) begin
      if (fuse_rd_en) rd_cyc++;
      if (fuse_strobe && !prev_s) begin
         if (pulses > 0 && int'(fuse_bit_idx) <= last_idx) order_bad++;
         if (pulses > 0 && int'(fuse_bit_idx) == last_idx + 1) begin
            if (gap_cnt < gmin) gmin = gap_cnt;
            if (gap_cnt > gmax) gmax = gap_cnt;
         end
         if (fmem[fuse_addr][fuse_bit_idx]) dbl++;
         if (fuse_bit_val) fmem[fuse_addr][fuse_bit_idx] = 1'b1;
         pulses++;
         last_idx = int'(fuse_bit_idx);
         cur_w = 1;
      end else if (fuse_strobe) begin
         cur_w++;
      end else if (prev_s) begin
         if (cur_w < wmin) wmin = cur_w;
         if (cur_w > wmax) wmax = cur_w;
         gap_cnt = 1;
      end else begin
         gap_cnt++;
      end
      prev_s = fuse_strobe;
   end

   task automatic clear_mon();
      pulses = 0; dbl = 0; order_bad = 0; rd_cyc = 0; cur_w = 0;
      wmin = 9999; wmax = 0; gmin = 9999; gmax = 0; gap_cnt = 0; last_idx = -1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] v);
      @(negedge clk);
      reg_sel = sel;
      #1 v = reg_rdata;
   endtask

   task automatic do_op(input logic [7:0] a, input logic [31:0] d);
      wr(S_CTRL, KEYW | 32'(a));
      wr(S_DATA, d);
   endtask

   task automatic wait_idle(output logic [31:0] v);
      for (int i = 0; i < 5000; i++) begin
         rd(S_CTRL, v);
         if (!v[8]) return;
      end
      chk("busy never cleared", 32'd1, 32'd0);
   endtask

   task automatic wait_quiet();
      logic [31:0] v;
      for (int i = 0; i < 5000; i++) begin
         rd(S_CTRL, v);
         if (!v[8] && !v[12]) return;
      end
      chk("quiet never ended", 32'd1, 32'd0);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(S_CTRL, v); chk("R1 ctrl after reset", v, 32'h0);
      rd(S_TIME, v); chk("R1 timing after reset", v, 32'h0);
      rd(S_DATA, v); chk("R1 data after reset", v, 32'h0);
      chk("R1 strobe low", {31'b0, fuse_strobe}, 32'h0);
      chk("R1 read enable low", {31'b0, fuse_rd_en}, 32'h0);
   endtask

   task automatic t_timing_reg();
      logic [31:0] v;
      wr(S_TIME, 32'hFFFF_FFFF);
      rd(S_TIME, v); chk("R10 timing field mask", v, 32'h003F_FFFF);
      wr(S_TIME, 32'h0003_2005);
      rd(S_TIME, v); chk("R10 timing readback", v, 32'h0003_2005);
   endtask

   task automatic t_basic();
      logic [31:0] v;
      fmem[8'h12] = 32'h0;
      clear_mon();
      do_op(8'h12, 32'h8000_0007);
      reg_sel = S_CTRL; #1;
      chk("R3 busy after accepted start", {31'b0, reg_rdata[8]}, 32'h1);
      chk("R3 key field cleared", {16'b0, reg_rdata[31:16]}, 32'h0);
      wait_idle(v);
      chk("R5 fuse word burned", fmem[8'h12], 32'h8000_0007);
      chk("R5 strobe count", pulses, 32'd4);
      chk("R5 strobe width min", wmin, 32'd5);
      chk("R5 strobe width max", wmax, 32'd5);
      chk("R5 ascending order", order_bad, 32'd0);
      chk("R11 adjacent gap relax=2", gmin, 32'd5);
      chk("R11 adjacent gap max", gmax, 32'd5);
      chk("R4 read enable cycles", rd_cyc, 32'd3);
      wait_quiet();
   endtask

   task automatic t_key_once();
      logic [31:0] v;
      clear_mon();
      wr(S_DATA, 32'h0000_0100);
      repeat (10) @(negedge clk);
      rd(S_CTRL, v); chk("R3 reuse without key not busy", {31'b0, v[8]}, 32'h0);
      chk("R3 reuse without key no strobe", pulses, 32'd0);
      chk("R3 word untouched", fmem[8'h12], 32'h8000_0007);
   endtask

   task automatic t_mask();
      logic [31:0] v;
      fmem[8'h20] = 32'h0000_00F0;
      clear_mon();
      do_op(8'h20, 32'h0000_0FF0);
      wait_idle(v);
      chk("R4 masked strobe count", pulses, 32'd4);
      chk("R4 no double burn", dbl, 32'd0);
      chk("R4 merged word", fmem[8'h20], 32'h0000_0FF0);
      wait_quiet();
   endtask

   task automatic t_no_key();
      logic [31:0] v;
      fmem[8'h22] = 32'h0;
      clear_mon();
      wr(S_CTRL, 32'h0000_0022);
      wr(S_DATA, 32'h0000_00FF);
      repeat (10) @(negedge clk);
      rd(S_CTRL, v); chk("R2 no key no busy", {31'b0, v[8]}, 32'h0);
      rd(S_DATA, v); chk("R2 data reg unchanged", v, 32'h0);
      chk("R2 no fuse read", rd_cyc, 32'd0);
      chk("R2 word untouched", fmem[8'h22], 32'h0);
   endtask

   task automatic t_locked();
      logic [31:0] v;
      fmem[8'h30] = 32'h0; fmem[8'h31] = 32'h0;
      clear_mon();
      do_op(8'h30, 32'h0000_0001);
      rd(S_CTRL, v);
      chk("R8 error set", {31'b0, v[9]}, 32'h1);
      chk("R8 busy not set", {31'b0, v[8]}, 32'h0);
      chk("R8 key consumed", {16'b0, v[31:16]}, 32'h0);
      repeat (10) @(negedge clk);
      chk("R8 no fuse read", rd_cyc, 32'd0);
      chk("R8 no strobe", pulses, 32'd0);
      do_op(8'h31, 32'h0000_0004);
      rd(S_CTRL, v);
      chk("R8 ignored while error", {31'b0, v[8]}, 32'h0);
      chk("R8 key kept while error", {16'b0, v[31:16]}, 32'h3E77);
      wr(S_CLR, 32'h0000_0200);
      rd(S_CTRL, v); chk("R8 error cleared", {31'b0, v[9]}, 32'h0);
      wr(S_DATA, 32'h0000_0004);
      wait_idle(v);
      chk("R8 burn after clear", fmem[8'h31], 32'h0000_0004);
      wait_quiet();
   endtask

   task automatic t_addr_latch();
      logic [31:0] v;
      fmem[8'h40] = 32'h0; fmem[8'h41] = 32'h0;
      clear_mon();
      do_op(8'h40, 32'h0000_0001);
      wr(S_CTRL, 32'h0000_0041);
      wait_idle(v);
      chk("R6 latched word burned", fmem[8'h40], 32'h0000_0001);
      chk("R6 new address untouched", fmem[8'h41], 32'h0);
      wait_quiet();
   endtask

   task automatic t_shift();
      logic [31:0] v;
      bit seen = 1'b0;
      fmem[8'h50] = 32'h0000_0011;
      clear_mon();
      do_op(8'h50, 32'h0000_0F13);
      reg_sel = S_DATA; #1;
      chk("R7 data held during read", reg_rdata, 32'h0000_0F13);
      for (int i = 0; i < 200 && !seen; i++) begin
         @(negedge clk); #1;
         if (fuse_strobe) seen = 1'b1;
      end
      chk("R7 first strobe index", {27'b0, fuse_bit_idx}, 32'd1);
      chk("R7 shifted data at first strobe", reg_rdata, 32'h0000_0781);
      wr(S_DATA, 32'hFFFF_FFFF);
      wait_idle(v);
      rd(S_DATA, v); chk("R7 data zero at end", v, 32'h0);
      chk("R7 busy write ignored", fmem[8'h50], 32'h0000_0F13);
      chk("R7 strobe count", pulses, 32'd5);
      wait_quiet();
   endtask

   task automatic t_settle();
      logic [31:0] v;
      int n;
      fmem[8'h60] = 32'h0; fmem[8'h62] = 32'h0;
      do_op(8'h60, 32'h0000_0001);
      wait_idle(v);
      n = v[12] ? 1 : 0;
      for (int i = 0; i < 1000; i++) begin
         rd(S_CTRL, v);
         if (!v[12]) break;
         n++;
      end
      chk("R9 quiet window length", n, 32'd200);
      do_op(8'h61, 32'h0000_0001);
      wait_idle(v);
      do_op(8'h62, 32'h0000_0002);
      rd(S_CTRL, v);
      chk("R9 write in quiet ignored", {31'b0, v[8]}, 32'h0);
      chk("R9 key kept in quiet", {16'b0, v[31:16]}, 32'h3E77);
      wait_quiet();
      wr(S_DATA, 32'h0000_0002);
      wait_idle(v);
      chk("R9 burn after quiet", fmem[8'h62], 32'h0000_0002);
      wait_quiet();
   endtask

   task automatic t_zero_relax();
      logic [31:0] v;
      fmem[8'h21] = 32'h0;
      wr(S_TIME, 32'h0000_0001);
      clear_mon();
      do_op(8'h21, 32'h0000_0003);
      wait_idle(v);
      chk("R11 zero relax gap", gmin, 32'd3);
      chk("R5 width prog=1", wmax, 32'd1);
      chk("R4 read zero acts as one", rd_cyc, 32'd1);
      chk("R11 word burned", fmem[8'h21], 32'h0000_0003);
      wait_quiet();
   endtask

   initial begin
      for (int i = 0; i < 256; i++) fmem[i] = 32'h0;
      lock_vec[8'h30] = 1'b1;
      clear_mon();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_timing_reg();
      t_basic();
      t_key_once();
      t_mask();
      t_no_key();
      t_locked();
      t_addr_latch();
      t_shift();
      t_settle();
      t_zero_relax();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule